// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives characters from an idle-high NRZ serial line. A 16x clock enable from an external rate generator sets the sample rate. The line is first passed through a synchronizer. Every 16x enable shifts the synchronized level into a short history. A start is accepted only when a low sample arrives right after three high samples. After a start, a sample counter steps through each bit cell. The value of every bit is the majority of the three samples at the centre of its cell. Data bits arrive least significant bit first. One of four frame layouts is chosen through a two-bit format input.

When a character is finished, its data lands in a holding register and a ready flag rises. The ninth data bit, the parity result, noise and framing errors are kept in a six-bit status word. Reading the data through a one-cycle read strobe clears the ready and overrun flags. The error flags and the ninth bit always describe the most recently completed character.

The controller is a state machine with these states:
- `S_IDLE` waits for a start.
- `S_START` confirms the start bit.
- `S_DATA` shifts in 8 or 9 bits.
- `S_PAR` checks the parity bit.
- `S_STOP1` and `S_STOP2` check the stop bits.

Its transitions are:
- start seen: `S_IDLE` to `S_START`.
- false start: `S_START` to `S_IDLE`.
- start confirmed: `S_START` to `S_DATA`.
- data done: `S_DATA` to `S_PAR` in format 2, otherwise to `S_STOP1`.
- parity done: `S_PAR` to `S_STOP1`.
- second stop pending: `S_STOP1` to `S_STOP2` in format 1.
- complete: `S_STOP1` or `S_STOP2` to `S_IDLE`, at the centre of the last stop bit.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset, `data_o` and `status_o` are all zero. The line is only examined on cycles where `tick16_i` is high.
- R2: A start is recognised only when a low sample immediately follows three high samples. A line held low from reset produces no character.
- R3: If the majority vote in the middle of the start bit reads 1, the receiver returns to idle. This false start raises no flag and produces no character.
- R4: `fmt_i` selects the frame layout:
  - 0: 8 data bits, 1 stop bit.
  - 1: 8 data bits, 2 stop bits.
  - 2: 8 data bits, a parity bit, 1 stop bit.
  - 3: 9 data bits, 1 stop bit.
  Data bits are received least significant bit first, and the low 8 data bits appear on `data_o`.
- R5: Each bit value is the majority of sub-bit samples 7, 8 and 9 (counting the first start sample as 0). If these three samples disagree within any bit of the frame, noise flag `status_o[4]` is set for that character, and the bit value still follows the majority.
- R6: In format 2, `par_odd_i`=0 demands an even count of ones over the data and parity bits, and 1 demands an odd count. A mismatch sets `status_o[3]`.
- R7: In format 3, the ninth data bit is stored in `status_o[2]`. In every other format `status_o[2]` is 0.
- R8: A stop bit voted as 0 sets frame error `status_o[5]`. In format 1, either stop bit being low sets it.
- R9: A completed character sets ready `status_o[0]`. A `rd_i` pulse clears both `status_o[0]` and `status_o[1]`.
- R10: If a character completes while ready is still set, overrun `status_o[1]` is set and `data_o` holds the newer character.
- R11: `status_o[2]`..`status_o[5]` are updated only when a character completes, and `rd_i` leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Sample enable at 16 times the bit rate |
| rxd_i | input | 1 | Serial input line, idle high |
| fmt_i | input | 2 | Frame layout select (see R4) |
| par_odd_i | input | 1 | Parity sense in format 2: 0 even, 1 odd |
| rd_i | input | 1 | One-cycle data read strobe |
| data_o | output | 8 | Last received data byte |
| status_o | output | 6 | {frame err, noise, parity err, ninth bit, overrun, ready} |

## Verification
The main function is tried with a fixed set of directed frames, one per format, and a seeded random mix of formats, data words and parity sense:
- Corrupted parity bits separate the even and odd parity senses.
- Low stop bits in either position show whether both stops of the two-stop layout are checked.
- A single flipped centre sample shows that the majority vote takes the value while the noise flag still records the disagreement.
- A line held low from reset and a short low pulse separate true starts from the three-high-sample history rule and from false starts.
- Back-to-back characters without a read separate overrun from plain replacement of the held data.

// File: rtl/osr_rx_pkg.sv
`timescale 1ns/1ps
package osr_rx_pkg;

    typedef enum logic [1:0] {
        FMT_8N1 = 2'd0,
        FMT_8N2 = 2'd1,
        FMT_8P1 = 2'd2,
        FMT_9N1 = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP1 = 3'd4,
        S_STOP2 = 3'd5
    } rx_state_e;

    localparam int ST_READY = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_BIT9  = 2;
    localparam int ST_PERR  = 3;
    localparam int ST_NOISE = 4;
    localparam int ST_FERR  = 5;
    localparam int ST_W     = 6;

endpackage

// File: rtl/osr_sync.sv
`timescale 1ns/1ps
module osr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/osr_start_det.sv
`timescale 1ns/1ps
module osr_start_det #(
    parameter int HIST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic line_i,
    output logic start_o
);
    logic [HIST_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hist_q <= '0;
        else if (tick_i) hist_q <= {hist_q[HIST_LEN-2:0], line_i};
    end

    assign start_o = tick_i && !line_i && (&hist_q);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (hist_q[0] == 1'b0));
endmodule

// File: rtl/osr_vote.sv
`timescale 1ns/1ps
module osr_vote #(
    parameter int OSR   = 16,
    parameter int CNT_W = $clog2(OSR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             line_i,
    output logic             valid_o,
    output logic             vote_o,
    output logic             noisy_o
);
    localparam int MID = OSR / 2;
    localparam logic [CNT_W-1:0] POS_A = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] POS_B = CNT_W'(MID);
    localparam logic [CNT_W-1:0] POS_C = CNT_W'(MID + 1);

    logic samp_a_q, samp_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_a_q <= 1'b1;
            samp_b_q <= 1'b1;
        end else if (tick_i && active_i) begin
            if (cnt_i == POS_A) samp_a_q <= line_i;
            if (cnt_i == POS_B) samp_b_q <= line_i;
        end
    end

    assign valid_o = tick_i && active_i && (cnt_i == POS_C);
    assign vote_o  = (samp_a_q & samp_b_q) | (samp_a_q & line_i) | (samp_b_q & line_i);
    assign noisy_o = !((samp_a_q == samp_b_q) && (samp_b_q == line_i));

    // R5
    unanimous_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !noisy_o) |-> (vote_o == line_i));
endmodule

// File: rtl/osr_hold.sv
`timescale 1ns/1ps
module osr_hold
    import osr_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              bit9_i,
    input  logic              perr_i,
    input  logic              noise_i,
    input  logic              ferr_i,
    output logic [DATA_W-1:0] data_o,
    output logic [ST_W-1:0]   status_o
);
    logic [DATA_W-1:0] data_q;
    logic [ST_W-1:0]   status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            status_q <= '0;
        end else if (done_i) begin
            data_q             <= data_i;
            status_q[ST_READY] <= 1'b1;
            status_q[ST_OVR]   <= !rd_i && (status_q[ST_OVR] || status_q[ST_READY]);
            status_q[ST_BIT9]  <= bit9_i;
            status_q[ST_PERR]  <= perr_i;
            status_q[ST_NOISE] <= noise_i;
            status_q[ST_FERR]  <= ferr_i;
        end else if (rd_i) begin
            status_q[ST_READY] <= 1'b0;
            status_q[ST_OVR]   <= 1'b0;
        end
    end

    assign data_o   = data_q;
    assign status_o = status_q;

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i) |=> (!status_q[ST_READY] && !status_q[ST_OVR]));
    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && status_q[ST_READY] && !rd_i) |=> status_q[ST_OVR]);
    // R11
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(status_q[ST_FERR:ST_BIT9]));
endmodule

// File: rtl/osr_uart_rx.sv
`timescale 1ns/1ps
module osr_uart_rx
    import osr_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int HIST_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16_i,
    input  logic       rxd_i,
    input  logic [1:0] fmt_i,
    input  logic       par_odd_i,
    input  logic       rd_i,
    output logic [7:0] data_o,
    output logic [5:0] status_o
);
    localparam int DATA_W = 8;
    localparam int SR_W   = DATA_W + 1;
    localparam int CNT_W  = $clog2(OSR);
    localparam int BIT_W  = $clog2(SR_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

    fmt_e       fmt;
    rx_state_e  state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [BIT_W-1:0] bit_q, bit_d, n_bits;
    logic [SR_W-1:0]  sr_q, sr_d;
    logic noise_q, noise_d, perr_q, perr_d, ferr_q, ferr_d;
    logic line_s, start_seen, vote_valid, vote, noisy, bit_end, done, nine;
    logic [DATA_W-1:0] byte_out;

    assign fmt    = fmt_e'(fmt_i);
    assign nine   = (fmt == FMT_9N1);
    assign n_bits = nine ? BIT_W'(SR_W) : BIT_W'(DATA_W);

    osr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(line_s)
    );

    osr_start_det #(.HIST_LEN(HIST_LEN)) sdet_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16_i), .line_i(line_s),
        .start_o(start_seen)
    );

    osr_vote #(.OSR(OSR), .CNT_W(CNT_W)) vote_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16_i),
        .active_i(state_q != S_IDLE), .cnt_i(cnt_q), .line_i(line_s),
        .valid_o(vote_valid), .vote_o(vote), .noisy_o(noisy)
    );

    assign bit_end = tick16_i && (state_q != S_IDLE) && (cnt_q == CNT_LAST);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sr_q    <= '0;
            noise_q <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            sr_q    <= sr_d;
            noise_q <= noise_d;
            perr_q  <= perr_d;
            ferr_q  <= ferr_d;
        end
    end

    // next-state and output process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bit_d   = bit_q;
        sr_d    = sr_q;
        noise_d = noise_q;
        perr_d  = perr_q;
        ferr_d  = ferr_q;
        done    = 1'b0;
        if (tick16_i && state_q != S_IDLE)
            cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        if (vote_valid)
            noise_d = noise_q | noisy;
        unique case (state_q)
            S_IDLE: begin
                if (start_seen) begin
                    state_d = S_START;
                    cnt_d   = CNT_W'(1);
                    bit_d   = '0;
                    sr_d    = '0;
                    noise_d = 1'b0;
                    perr_d  = 1'b0;
                    ferr_d  = 1'b0;
                end
            end
            S_START: begin
                if (vote_valid && vote)
                    state_d = S_IDLE;
                else if (bit_end)
                    state_d = S_DATA;
            end
            S_DATA: begin
                if (vote_valid) begin
                    sr_d  = {vote, sr_q[SR_W-1:1]};
                    bit_d = bit_q + 1'b1;
                end else if (bit_end && bit_q == n_bits) begin
                    state_d = (fmt == FMT_8P1) ? S_PAR : S_STOP1;
                end
            end
            S_PAR: begin
                if (vote_valid)
                    perr_d = (^sr_q[SR_W-1:1]) ^ vote ^ par_odd_i;
                else if (bit_end)
                    state_d = S_STOP1;
            end
            S_STOP1: begin
                if (vote_valid) begin
                    ferr_d = ferr_q | !vote;
                    if (fmt != FMT_8N2) begin
                        done    = 1'b1;
                        state_d = S_IDLE;
                    end
                end else if (bit_end) begin
                    state_d = S_STOP2;
                end
            end
            S_STOP2: begin
                if (vote_valid) begin
                    ferr_d  = ferr_q | !vote;
                    done    = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign byte_out = nine ? sr_q[DATA_W-1:0] : sr_q[SR_W-1:1];

    osr_hold #(.DATA_W(DATA_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .done_i(done), .rd_i(rd_i),
        .data_i(byte_out), .bit9_i(nine & sr_q[SR_W-1]),
        .perr_i(perr_d), .noise_i(noise_d), .ferr_i(ferr_d),
        .data_o(data_o), .status_o(status_o)
    );

    // R1
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !tick16_i) |=> (state_q == S_IDLE));
    // R3
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && vote_valid && vote) |=> (state_q == S_IDLE && !$rose(status_o[ST_READY])));
    // R4
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= BIT_W'(SR_W));
    // R7
    ninth_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fmt != FMT_9N1) |=> !status_o[ST_BIT9]);
endmodule

// File: tb/osr_uart_rx_tb.sv
`timescale 1ns/1ps
module osr_uart_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b0;
    logic [1:0] fmt = 2'd0;
    logic       odd = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] data;
    logic [5:0] status;
    logic [1:0] div = 2'd0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        div  <= div + 2'd1;
        tick <= (div == 2'd3);
    end

    osr_uart_rx dut_i (
        .clk(clk), .rst_n(rst_n), .tick16_i(tick), .rxd_i(rxd),
        .fmt_i(fmt), .par_odd_i(odd), .rd_i(rd),
        .data_o(data), .status_o(status)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tk();
        @(posedge clk);
        while (tick !== 1'b1) @(posedge clk);
        #1;
    endtask

    task automatic drv(input logic v);
        rxd = v;
        tk();
    endtask

    task automatic send_bit(input logic v, input bit noisy);
        for (int k = 0; k < 16; k++) drv((noisy && k == 8) ? ~v : v);
    endtask

    task automatic do_read();
        @(posedge clk); #1 rd = 1'b1;
        @(posedge clk); #1 rd = 1'b0;
    endtask

    function automatic logic [5:0] exp_stat(input logic [1:0] f, input logic [8:0] d,
            input bit bp, input bit bs1, input bit bs2, input bit nz, input bit rdy, input bit ovr);
        logic [5:0] s;
        s[0] = rdy;
        s[1] = ovr;
        s[2] = (f == 2'd3) ? d[8] : 1'b0;
        s[3] = (f == 2'd2) && bp;
        s[4] = nz;
        s[5] = bs1 || (f == 2'd1 && bs2);
        return s;
    endfunction

    task automatic send_frame(input logic [1:0] f, input logic [8:0] d, input bit bp,
            input bit bs1, input bit bs2, input int nb);
        int nbits;
        logic p;
        fmt   = f;
        nbits = (f == 2'd3) ? 9 : 8;
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < nbits; i++) send_bit(d[i], nb == i);
        if (f == 2'd2) begin
            p = (^d[7:0]) ^ odd ^ bp;
            send_bit(p, 1'b0);
        end
        send_bit(!bs1, 1'b0);
        if (f == 2'd1) send_bit(!bs2, 1'b0);
        for (int i = 0; i < 24; i++) drv(1'b1);
    endtask

    task automatic do_frame(input string req, input logic [1:0] f, input logic [8:0] d,
            input bit bp, input bit bs1, input bit bs2, input int nb);
        logic [5:0] e;
        send_frame(f, d, bp, bs1, bs2, nb);
        e = exp_stat(f, d, bp, bs1, bs2, nb >= 0, 1'b1, 1'b0);
        chk({req, " data R4"}, 16'(data), 16'(d[7:0]));
        chk({req, " status"}, 16'(status), 16'(e));
        do_read();
        // R9 ready clears; R11 error flags survive the read
        chk({req, " after read R9 R11"}, 16'(status), 16'(e & 6'b111100));
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4411));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset status", 16'(status), 16'h0);
        chk("R1 reset data", 16'(data), 16'h0);

        // R2: line low from reset, no three highs ever seen
        for (int i = 0; i < 60; i++) drv(1'b0);
        chk("R2 low line no start", 16'(status), 16'h0);
        for (int i = 0; i < 20; i++) drv(1'b1);

        // R3: short low pulse is a false start
        for (int i = 0; i < 5; i++) drv(1'b0);
        for (int i = 0; i < 40; i++) drv(1'b1);
        chk("R3 false start", 16'(status), 16'h0);

        // directed per format
        odd = 1'b0;
        do_frame("R4 8N1", 2'd0, 9'h0A5, 0, 0, 0, -1);
        do_frame("R4 8N2", 2'd1, 9'h03C, 0, 0, 0, -1);
        do_frame("R6 even good", 2'd2, 9'h081, 0, 0, 0, -1);
        do_frame("R6 even bad", 2'd2, 9'h0F7, 1, 0, 0, -1);
        odd = 1'b1;
        do_frame("R6 odd good", 2'd2, 9'h081, 0, 0, 0, -1);
        do_frame("R6 odd bad", 2'd2, 9'h013, 1, 0, 0, -1);
        do_frame("R7 ninth one", 2'd3, 9'h1C3, 0, 0, 0, -1);
        do_frame("R7 ninth zero", 2'd3, 9'h0FF, 0, 0, 0, -1);
        do_frame("R8 stop low", 2'd0, 9'h055, 0, 1, 0, -1);
        do_frame("R8 second stop low", 2'd1, 9'h066, 0, 0, 1, -1);
        do_frame("R8 first stop low 2-stop", 2'd1, 9'h077, 0, 1, 0, -1);
        do_frame("R5 noise", 2'd0, 9'h05A, 0, 0, 0, 3);
        // R11: clean frame clears previous error flags
        do_frame("R11 clean", 2'd0, 9'h011, 0, 0, 0, -1);

        // R10 overrun
        send_frame(2'd0, 9'h021, 0, 0, 0, -1);
        chk("R10 first ready", 16'(status), 16'h01);
        send_frame(2'd0, 9'h0C4, 0, 0, 0, -1);
        chk("R10 overrun set", 16'(status), 16'h03);
        chk("R10 newer data", 16'(data), 16'h0C4);
        do_read();
        chk("R9 read clears overrun", 16'(status), 16'h00);

        // random mix
        for (int n = 0; n < 40; n++) begin
            logic [1:0] f;
            logic [8:0] d;
            bit bp, b1, b2;
            int nb;
            f   = 2'($urandom % 4);
            d   = 9'($urandom);
            odd = 1'($urandom);
            bp  = ($urandom % 3) == 0;
            b1  = ($urandom % 5) == 0;
            b2  = ($urandom % 5) == 0;
            nb  = (($urandom % 3) == 0) ? int'($urandom % 8) : -1;
            do_frame("R4 R5 R6 R7 R8 random", f, d, bp, b1, b2, nb);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule